// File: doc/BRIEF.md
# Serial Receive Path with Overflow and Mode-Fault Detection

This block is the receive half of a synchronous serial port. It samples one data line on each rising edge of the serial clock. It assembles a byte with the most significant bit arriving first, and hands each completed byte to a holding register that software reads. A receive-full flag tells software that a byte is waiting. A separate receive interrupt can be enabled on that flag.

The block reports two error conditions:

- **Overflow.** A new byte starts arriving while the previous byte has not been consumed. The new byte is discarded and the old byte stays readable.
- **Mode fault.** The select input is pulled active while the port is configured as the bus master. The port then drops out of master mode and disables itself.

Both errors share one error interrupt enable. A separate enable decides whether a mode fault can be recorded at all.

Software reaches the block through a small register port. Reads are combinational on `reg_rdata` and take effect, for flag clearing, at the clock edge where `reg_rd` is high. Each flag is cleared by a two-step sequence: a status read that sees the flag set, followed by an access to the data or control register.

Top module: `spirx_err_top`

## Requirements
- R1: Register map, with all fields reset to 0:
  - Address 0, control (read/write): bit0 enable, bit1 master, bit2 receive interrupt enable, bit3 error interrupt enable, bit4 mode-fault enable.
  - Address 1, status (read only): bit0 receive-full, bit1 overflow, bit2 mode fault.
  - Address 2, data (read only).
  - Address 3 reads 0.
- R2: While enabled and either master or selected (`ss_n` low), each rising edge of `sclk` captures `sdin`, MSB first. After the eighth capture, the byte moves into the data register and receive-full sets, unless overflow applies.
- R3: Receive-full clears only when a status read that saw it set is followed by a data read. A data read with no such prior status read leaves it set.
- R4: If receive-full is still set at the first capture of the next byte, overflow sets at that capture.
- R5: A byte whose first capture found receive-full set is never transferred. The older byte remains readable in the data register.
- R6: Overflow clears when a status read that saw it set is followed by a data read.
- R7: While master, with mode-fault enable set and `ss_n` low, mode fault sets. The same edge clears the enable and master bits, and no bits are captured while mode fault stays set.
- R8: With mode-fault enable clear, a low `ss_n` in master mode never sets mode fault.
- R9: Mode fault clears when a status read that saw it set is followed by a control write. A control write without that prior status read leaves it set and cannot set the enable or master bits.
- R10: `irq_err` is high exactly when error interrupt enable is set and overflow or mode fault is set. `irq_rx` is high exactly when receive interrupt enable and receive-full are both set.
- R11: Raising `ss_n` while a slave, or clearing enable, discards a partially assembled byte. The next byte is framed from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, already synchronous to clk |
| sdin | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low select input |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives flag clearing) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench targets the following corner cases, and each names the failure it would expose:

- **Back-to-back bytes with no read between them.** A design that checks for overflow at byte completion instead of at the first capture, or that overwrites the held byte, returns the newer value or flags nothing.
- **Data reads without an arming status read.** A design that clears receive-full on any data read loses the flag.
- **Plain control writes during a mode fault.** A design that clears the fault on any control write drops the fault, or re-enables master mode while the fault is still pending.
- **Select rising mid-byte, and mode-fault enable held low.** These show a stale bit counter as a misframed byte, and an ungated fault as a spurious error interrupt.

// File: rtl/spirx_pkg.sv
package spirx_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_MST    = 1;
  localparam int unsigned CB_RXIE   = 2;
  localparam int unsigned CB_ERRIE  = 3;
  localparam int unsigned CB_MFEN   = 4;
  localparam int unsigned CTRL_BITS = 5;

  // status bit positions
  localparam int unsigned SB_FULL = 0;
  localparam int unsigned SB_OVF  = 1;
  localparam int unsigned SB_MF   = 2;

  function automatic logic err_request(input logic errie, input logic ovf, input logic mf);
    return errie & (ovf | mf);
  endfunction

  function automatic logic mf_condition(input logic mst, input logic mfen, input logic ss_n);
    return mst & mfen & ~ss_n;
  endfunction
endpackage

// File: rtl/spirx_shift.sv
module spirx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sclk,
  input  logic              sdin,
  output logic              first_cap,
  output logic              last_cap,
  output logic [DATA_W-1:0] byte_asm
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] sr, input logic b);
    return {sr[DATA_W-2:0], b};
  endfunction

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr;
  logic              rise;

  assign rise      = run & sclk & ~sclk_q;
  assign first_cap = rise & (cnt == '0);
  assign last_cap  = rise & (cnt == LAST);
  assign byte_asm  = shift_in(sr, sdin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      if (!run) begin
        cnt <= '0;
      end else if (rise) begin
        sr  <= byte_asm;
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spirx_flags.sv
module spirx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_cap,
  input  logic              last_cap,
  input  logic [DATA_W-1:0] byte_asm,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic              mf_set,
  output logic              rx_full,
  output logic              ovf,
  output logic              mf,
  output logic              mf_clr,
  output logic              load_evt,
  output logic [DATA_W-1:0] rx_data
);
  logic drop_q, drop_now;
  logic arm_full, arm_ovf, arm_mf;
  logic full_clr, ovf_clr, ovf_set;

  assign drop_now = first_cap ? rx_full : drop_q;
  assign load_evt = last_cap & ~drop_now;
  assign ovf_set  = first_cap & rx_full;
  assign full_clr = data_rd & arm_full;
  assign ovf_clr  = data_rd & arm_ovf;
  assign mf_clr   = ctrl_wr & arm_mf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q   <= 1'b0;
      arm_full <= 1'b0;
      arm_ovf  <= 1'b0;
      arm_mf   <= 1'b0;
      rx_full  <= 1'b0;
      ovf      <= 1'b0;
      mf       <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (first_cap) drop_q <= rx_full;

      if (stat_rd) begin
        arm_full <= rx_full;
        arm_ovf  <= ovf;
        arm_mf   <= mf;
      end else begin
        if (data_rd) begin
          arm_full <= 1'b0;
          arm_ovf  <= 1'b0;
        end
        if (ctrl_wr) arm_mf <= 1'b0;
      end

      if (load_evt) begin
        rx_data <= byte_asm;
        rx_full <= 1'b1;
      end else if (full_clr) begin
        rx_full <= 1'b0;
      end

      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;

      if (mf_set)      mf <= 1'b1;
      else if (mf_clr) mf <= 1'b0;
    end
  end
endmodule

// File: rtl/spirx_err_top.sv
module spirx_err_top
  import spirx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              ss_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_rx,
  output logic              irq_err
);
  logic en, mst, rxie, errie, mfen;
  logic run, first_cap, last_cap, load_evt;
  logic stat_rd, data_rd, ctrl_wr;
  logic mf_set, mf_clr, rx_full, ovf, mf;
  logic [DATA_W-1:0] byte_asm, rx_data;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata[DATA_W-1:CTRL_BITS];

  assign stat_rd = reg_rd & (reg_addr == A_STAT);
  assign data_rd = reg_rd & (reg_addr == A_DATA);
  assign ctrl_wr = reg_wr & (reg_addr == A_CTRL);
  assign mf_set  = mf_condition(mst, mfen, ss_n);
  assign run     = en & (mst | ~ss_n) & ~mf;

  spirx_shift #(.DATA_W(DATA_W)) shift_i (
    .clk, .rst_n, .run, .sclk, .sdin,
    .first_cap, .last_cap, .byte_asm
  );

  spirx_flags #(.DATA_W(DATA_W)) flags_i (
    .clk, .rst_n, .first_cap, .last_cap, .byte_asm,
    .stat_rd, .data_rd, .ctrl_wr, .mf_set,
    .rx_full, .ovf, .mf, .mf_clr, .load_evt, .rx_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      mst   <= 1'b0;
      rxie  <= 1'b0;
      errie <= 1'b0;
      mfen  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rxie  <= reg_wdata[CB_RXIE];
        errie <= reg_wdata[CB_ERRIE];
        mfen  <= reg_wdata[CB_MFEN];
        en    <= reg_wdata[CB_EN]  & ~(mf & ~mf_clr);
        mst   <= reg_wdata[CB_MST] & ~(mf & ~mf_clr);
      end
      if (mf_set) begin
        en  <= 1'b0;
        mst <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CB_EN]    = en;
        reg_rdata[CB_MST]   = mst;
        reg_rdata[CB_RXIE]  = rxie;
        reg_rdata[CB_ERRIE] = errie;
        reg_rdata[CB_MFEN]  = mfen;
      end
      A_STAT: begin
        reg_rdata[SB_FULL] = rx_full;
        reg_rdata[SB_OVF]  = ovf;
        reg_rdata[SB_MF]   = mf;
      end
      A_DATA:  reg_rdata = rx_data;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_rx  = rxie & rx_full;
  assign irq_err = err_request(errie, ovf, mf);
endmodule

// File: rtl/spirx_err_chk.sv
module spirx_err_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              first_cap,
  input logic              last_cap,
  input logic              load_evt,
  input logic              rx_full,
  input logic              ovf,
  input logic              mf,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] byte_asm,
  input logic              en,
  input logic              mst,
  input logic              mfen,
  input logic              errie,
  input logic              irq_err
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> rx_full && (rx_data == $past(byte_asm)));

  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    first_cap && rx_full |=> ovf);

  a_r5_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    last_cap && !load_evt |=> $stable(rx_data));

  a_r7_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    mf |-> !en && !mst && !first_cap);

  a_r8_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !mfen && !mf |=> !mf);

  a_r10_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    errie && (ovf || mf) |-> irq_err);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !errie |-> !irq_err);
endmodule

bind spirx_err_top spirx_err_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .first_cap(first_cap), .last_cap(last_cap),
  .load_evt(load_evt), .rx_full(rx_full), .ovf(ovf), .mf(mf),
  .rx_data(rx_data), .byte_asm(byte_asm), .en(en), .mst(mst),
  .mfen(mfen), .errie(errie), .irq_err(irq_err)
);

// File: tb/spirx_err_top_tb.sv
`timescale 1ns/1ps
module spirx_err_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdin = 1'b0, ss_n = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_rx, irq_err;

  int n_vec = 0, n_bad = 0;
  logic [7:0] rd_v;
  logic [7:0] m_data;
  logic       m_full, m_ovf;

  always #2.5 clk = ~clk;

  spirx_err_top dut_i (.*);

  function automatic logic [7:0] exp_stat(input logic f, input logic o, input logic m);
    return {5'b0, m, o, f};
  endfunction

  function automatic logic [7:0] exp_ctrl(input logic e, input logic ms, input logic ri,
                                          input logic ei, input logic mfe);
    return {3'b0, mfe, ei, ri, ms, e};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      sdin = b[i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic model_send(input logic [7:0] b);
    send_bits(b, 8);
    if (m_full) begin
      m_ovf = 1'b1;
    end else begin
      m_full = 1'b1;
      m_data = b;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, rd_v); chk("R1 ctrl reset", rd_v, 8'h00);
    peek(2'd1, rd_v); chk("R1 stat reset", rd_v, 8'h00);
    peek(2'd3, rd_v); chk("R1 unused addr", rd_v, 8'h00);
    chk("R10 irq reset", {6'b0, irq_rx, irq_err}, 8'h00);

    // slave, enabled, both interrupts on
    wr(2'd0, exp_ctrl(1, 0, 1, 1, 0));
    peek(2'd0, rd_v); chk("R1 ctrl write", rd_v, 8'h0D);
    ss_n = 1'b0;

    // R2 assembly, R10 rx irq
    send_bits(8'hA5, 8);
    chk("R10 irq_rx on full", {7'b0, irq_rx}, 8'h01);
    rd(2'd1, rd_v); chk("R2 full set", rd_v, exp_stat(1, 0, 0));
    rd(2'd2, rd_v); chk("R2 MSB-first byte", rd_v, 8'hA5);
    peek(2'd1, rd_v); chk("R3 cleared by sequence", rd_v, 8'h00);

    // R3 data read without arming status read
    send_bits(8'h3C, 8);
    rd(2'd2, rd_v); chk("R3 data", rd_v, 8'h3C);
    peek(2'd1, rd_v); chk("R3 unarmed read keeps full", rd_v, exp_stat(1, 0, 0));
    rd(2'd1, rd_v);
    rd(2'd2, rd_v);
    peek(2'd1, rd_v); chk("R3 armed clear", rd_v, 8'h00);

    // R4/R5/R6 overflow
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    chk("R10 irq_err on ovf", {7'b0, irq_err}, 8'h01);
    rd(2'd1, rd_v); chk("R4 ovf set", rd_v, exp_stat(1, 1, 0));
    rd(2'd2, rd_v); chk("R5 old byte kept", rd_v, 8'h11);
    peek(2'd1, rd_v); chk("R6 ovf cleared", rd_v, 8'h00);
    chk("R10 irq_err drops", {7'b0, irq_err}, 8'h00);

    // R4 first-capture timing: overflow already visible after one bit
    send_bits(8'h77, 8);
    send_bits(8'h80, 1);
    peek(2'd1, rd_v); chk("R4 ovf at first capture", rd_v, exp_stat(1, 1, 0));
    send_bits(8'h00, 7);
    rd(2'd1, rd_v);
    rd(2'd2, rd_v); chk("R5 keep after early ovf", rd_v, 8'h77);

    // random stream against the bench model
    m_full = 1'b0; m_ovf = 1'b0; m_data = 8'h77;
    void'($urandom(32'h5EED));
    for (int it = 0; it < 40; it++) begin
      model_send(8'($urandom));
      if ($urandom % 3 == 0) begin
        rd(2'd1, rd_v); chk("R4 random stat", rd_v, exp_stat(m_full, m_ovf, 0));
        rd(2'd2, rd_v); chk("R5 random data", rd_v, m_data);
        m_full = 1'b0; m_ovf = 1'b0;
      end
    end
    rd(2'd1, rd_v); chk("R6 random drain stat", rd_v, exp_stat(m_full, m_ovf, 0));
    rd(2'd2, rd_v); chk("R5 random drain data", rd_v, m_data);

    // R11 select rising mid-byte resets framing
    send_bits(8'hFF, 4);
    ss_n = 1'b1;
    repeat (3) @(negedge clk);
    ss_n = 1'b0;
    send_bits(8'h5A, 8);
    rd(2'd1, rd_v); chk("R11 one byte only", rd_v, exp_stat(1, 0, 0));
    rd(2'd2, rd_v); chk("R11 reframed byte", rd_v, 8'h5A);

    // R11 disabled port ignores the clock
    wr(2'd0, exp_ctrl(0, 0, 1, 1, 0));
    send_bits(8'hC3, 8);
    peek(2'd1, rd_v); chk("R11 disabled ignores", rd_v, 8'h00);
    chk("R10 irq_rx idle", {7'b0, irq_rx}, 8'h00);

    // R7 mode fault
    ss_n = 1'b1;
    wr(2'd0, exp_ctrl(1, 1, 0, 1, 1));
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd1, rd_v); chk("R7 fault set", rd_v, exp_stat(0, 0, 1));
    peek(2'd0, rd_v); chk("R7 forced off", rd_v, exp_ctrl(0, 0, 0, 1, 1));
    chk("R10 irq_err on fault", {7'b0, irq_err}, 8'h01);

    // R9 unarmed control write neither clears nor re-enables
    ss_n = 1'b1;
    wr(2'd0, exp_ctrl(1, 1, 0, 1, 1));
    peek(2'd1, rd_v); chk("R9 unarmed write keeps fault", rd_v, exp_stat(0, 0, 1));
    peek(2'd0, rd_v); chk("R9 write masked", rd_v, exp_ctrl(0, 0, 0, 1, 1));
    rd(2'd1, rd_v);
    wr(2'd0, exp_ctrl(0, 0, 0, 1, 1));
    peek(2'd1, rd_v); chk("R9 armed write clears", rd_v, 8'h00);
    chk("R10 irq_err cleared", {7'b0, irq_err}, 8'h00);

    // R8 mode-fault enable low
    wr(2'd0, exp_ctrl(1, 1, 0, 1, 0));
    ss_n = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd1, rd_v); chk("R8 no fault", rd_v, 8'h00);
    peek(2'd0, rd_v); chk("R8 still master", rd_v, exp_ctrl(1, 1, 0, 1, 0));
    ss_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule